// File: doc/BRIEF.md
# Capture/Compare Timer

A 16-bit counter that advances once per clock (through a fixed divide parameter), paired with two input-capture channels and two output-compare channels. Software reaches every 16-bit quantity through an 8-bit register bus, one high-byte register and one low-byte register per quantity, with the bus read data returned combinationally in the cycle the read strobe is high.

A capture channel watches its pin through a two-stage synchroniser, detects the edge kind chosen for it, copies the counter into its latch and raises its flag. A compare channel holds a 16-bit target. On the clock edge where the counter equals that target, it raises its flag and applies the chosen action to its output pin. Byte-pair coherence is enforced in hardware. Reading a capture high byte freezes that latch until its low byte is read. Writing a compare high byte suspends matching until its low byte is written. Reading the counter high byte snapshots the low byte for the next low-byte read.

Top module: `tmr_cc_top`

## Requirements
- R1: The counter resets to 0x0000 and increases by one on every clock edge, wrapping from 0xFFFF to 0x0000.
- R2: Reading address 0 returns counter bits 15:8 and snapshots bits 7:0. A later read of address 1 returns the snapshot; without a pending snapshot, address 1 returns the live low byte.
- R3: Flag bit 4 (address 11) sets on the edge where the counter wraps from 0xFFFF.
- R4: Control register (address 10) bits 1:0 and 3:2 select the edge for capture channels 0 and 1: 00 off, 01 rising, 10 falling, 11 both. A selected edge, seen after the two-stage synchroniser, copies the counter into the latch (channel 0 at addresses 2 and 3, channel 1 at 4 and 5, high byte first).
- R5: A capture sets flag bit 0 for channel 0 or bit 1 for channel 1.
- R6: Reading a capture high byte freezes that latch and its flag until its low byte is read; edges in between are dropped.
- R7: Control bits 5:4 and 7:6 select the compare action for channels 0 and 1: 00 none, 01 toggle, 10 clear, 11 set. The action is applied to the output pin, and flag bit 2 or 3 sets, on the edge where the counter equals the target.
- R8: Writing a compare high byte (address 6 for channel 0, address 8 for channel 1) suspends matching until the low byte (address 7 or 9) is written.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it. A set and a clear on the same edge leave the flag set.
- R10: After reset the control and flag registers read 0x00, both compare targets read 0xFFFF, and both output pins are low.
- R11: The compare target bytes and the control register read back as written. The unused addresses 12 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when no read is in progress |
| cap_pin | input | 2 | Capture inputs, asynchronous |
| cmp_pin | output | 2 | Compare outputs |

## Verification
Two kinds of internal fault show up at the ports. A latch that ignores its freeze, or a compare that matches while suspended, shows as a wrong byte on the next bus read or a wrong pin level on the very next clock edge. A counter that skips or stalls shifts every later capture value and every compare event, so the first read or pin check after the fault exposes it. The bench drives edges, byte-pair accesses and flag writes in chosen orders, including a flag clear on the exact wrap edge. A behavioural model predicts the pins every cycle and every byte returned by a read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'b00,
      EDGE_RISE = 2'b01,
      EDGE_FALL = 2'b10,
      EDGE_BOTH = 2'b11
   } edge_sel_e;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_TOGGLE = 2'b01,
      ACT_CLEAR  = 2'b10,
      ACT_SET    = 2'b11
   } cmp_act_e;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [DW-1:0] LAST = DW'(DIV - 1);

   logic [DW-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             div_q <= '0;
      else if (div_q == LAST) div_q <= '0;
      else                    div_q <= div_q + 1'b1;
   end

   assign tick = (div_q == LAST);
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
   import tmr_pkg::*;
#(
   parameter int CW          = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pin,
   input  edge_sel_e     edge_sel,
   input  logic [CW-1:0] count,
   input  logic          freeze_set,
   input  logic          freeze_clr,
   output logic [CW-1:0] cap_val,
   output logic          cap_hit,
   output logic          hold
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   pin_s;
   logic                   prev_q;
   logic                   rise, fall, trig;

   generate
      if (SYNC_STAGES == 2) begin : g_sync2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[0], pin};
         end
      end else begin : g_syncn
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         end
      end
   endgenerate

   assign pin_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= pin_s;
   end

   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;

   always_comb begin
      unique case (edge_sel)
         EDGE_RISE: trig = rise;
         EDGE_FALL: trig = fall;
         EDGE_BOTH: trig = rise | fall;
         default:   trig = 1'b0;
      endcase
   end

   assign cap_hit = trig & ~hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          hold <= 1'b0;
      else if (freeze_set) hold <= 1'b1;
      else if (freeze_clr) hold <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cap_val <= '0;
      else if (cap_hit) cap_val <= count;
   end
endmodule

// File: rtl/tmr_compare.sv
module tmr_compare
   import tmr_pkg::*;
#(
   parameter int CW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [CW-1:0] count,
   input  logic          wr_hi,
   input  logic          wr_lo,
   input  logic [BW-1:0] wdata,
   input  cmp_act_e      act,
   output logic [CW-1:0] cmp_val,
   output logic          hold,
   output logic          cmp_hit,
   output logic          pin
);
   assign cmp_hit = tick & ~hold & (count == cmp_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_val <= '1;
         hold    <= 1'b0;
      end else if (wr_hi) begin
         cmp_val[CW-1:BW] <= wdata;
         hold             <= 1'b1;
      end else if (wr_lo) begin
         cmp_val[BW-1:0] <= wdata;
         hold            <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin <= 1'b0;
      else if (cmp_hit) begin
         unique case (act)
            ACT_TOGGLE: pin <= ~pin;
            ACT_CLEAR:  pin <= 1'b0;
            ACT_SET:    pin <= 1'b1;
            default:    pin <= pin;
         endcase
      end
   end
endmodule

// File: rtl/tmr_cc_top.sv
module tmr_cc_top
   import tmr_pkg::*;
#(
   parameter int CW          = 16,
   parameter int BW          = 8,
   parameter int NCAP        = 2,
   parameter int NCMP        = 2,
   parameter int DIV         = 1,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [AW-1:0]   bus_addr,
   input  logic            bus_wr,
   input  logic            bus_rd,
   input  logic [BW-1:0]   bus_wdata,
   output logic [BW-1:0]   bus_rdata,
   input  logic [NCAP-1:0] cap_pin,
   output logic [NCMP-1:0] cmp_pin
);
   localparam int NFLAG    = NCAP + NCMP + 1;
   localparam int CAP_BASE = 2;
   localparam int CMP_BASE = CAP_BASE + 2 * NCAP;
   localparam int A_CTRL   = CMP_BASE + 2 * NCMP;
   localparam int A_FLAG   = A_CTRL + 1;
   localparam int NREG     = A_FLAG + 1;
   localparam int OVF_BIT  = NCAP + NCMP;

   generate
      if (CW != 2 * BW) begin : g_bad_width
         $error("counter width must be twice the bus width");
      end
      if (2 * (NCAP + NCMP) > BW) begin : g_bad_ctrl
         $error("channel control fields do not fit one register");
      end
      if (NFLAG > BW) begin : g_bad_flags
         $error("flags do not fit one register");
      end
      if (NREG > (1 << AW)) begin : g_bad_addr
         $error("address width too small for the register map");
      end
      if (DIV < 1 || SYNC_STAGES < 2) begin : g_bad_misc
         $error("divide must be at least 1 and synchroniser at least 2 stages");
      end
   endgenerate

   logic              tick;
   logic [CW-1:0]     count;
   logic              wrap;
   logic [BW-1:0]     cnt_snap;
   logic              cnt_held;
   logic [BW-1:0]     ctrl_q;
   logic [NFLAG-1:0]  flags;
   logic [NFLAG-1:0]  flag_set;
   logic [NFLAG-1:0]  flag_clr;
   logic [NCAP-1:0]   cap_hit;
   logic [NCAP-1:0]   cap_hold;
   logic [CW-1:0]     cap_val [NCAP];
   logic [NCMP-1:0]   cmp_hit;
   logic [NCMP-1:0]   cmp_hold;
   logic [CW-1:0]     cmp_val [NCMP];
   logic [BW-1:0]     rd_val;

   tmr_tick #(.DIV(DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    count <= '0;
      else if (tick) count <= count + 1'b1;
   end

   assign wrap = tick & (count == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_snap <= '0;
         cnt_held <= 1'b0;
      end else if (bus_rd && bus_addr == AW'(0)) begin
         cnt_snap <= count[BW-1:0];
         cnt_held <= 1'b1;
      end else if (bus_rd && bus_addr == AW'(1)) begin
         cnt_held <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ctrl_q <= '0;
      else if (bus_wr && bus_addr == AW'(A_CTRL)) ctrl_q <= bus_wdata;
   end

   generate
      for (genvar i = 0; i < NCAP; i++) begin : g_cap
         logic frz_set, frz_clr;
         assign frz_set = bus_rd && (bus_addr == AW'(CAP_BASE + 2 * i));
         assign frz_clr = bus_rd && (bus_addr == AW'(CAP_BASE + 2 * i + 1));
         tmr_capture #(.CW(CW), .SYNC_STAGES(SYNC_STAGES)) u_cap (
            .clk        (clk),
            .rst_n      (rst_n),
            .pin        (cap_pin[i]),
            .edge_sel   (edge_sel_e'(ctrl_q[2*i +: 2])),
            .count      (count),
            .freeze_set (frz_set),
            .freeze_clr (frz_clr),
            .cap_val    (cap_val[i]),
            .cap_hit    (cap_hit[i]),
            .hold       (cap_hold[i])
         );
      end

      for (genvar j = 0; j < NCMP; j++) begin : g_cmp
         logic w_hi, w_lo;
         assign w_hi = bus_wr && (bus_addr == AW'(CMP_BASE + 2 * j));
         assign w_lo = bus_wr && (bus_addr == AW'(CMP_BASE + 2 * j + 1));
         tmr_compare #(.CW(CW), .BW(BW)) u_cmp (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .count   (count),
            .wr_hi   (w_hi),
            .wr_lo   (w_lo),
            .wdata   (bus_wdata),
            .act     (cmp_act_e'(ctrl_q[2*(NCAP+j) +: 2])),
            .cmp_val (cmp_val[j]),
            .hold    (cmp_hold[j]),
            .cmp_hit (cmp_hit[j]),
            .pin     (cmp_pin[j])
         );
      end
   endgenerate

   assign flag_set = {wrap, cmp_hit, cap_hit};
   assign flag_clr = (bus_wr && bus_addr == AW'(A_FLAG)) ? bus_wdata[NFLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~flag_clr) | flag_set;
   end

   always_comb begin
      rd_val = '0;
      if (bus_addr == AW'(0)) rd_val = count[CW-1:BW];
      if (bus_addr == AW'(1)) rd_val = cnt_held ? cnt_snap : count[BW-1:0];
      for (int i = 0; i < NCAP; i++) begin
         if (bus_addr == AW'(CAP_BASE + 2 * i))     rd_val = cap_val[i][CW-1:BW];
         if (bus_addr == AW'(CAP_BASE + 2 * i + 1)) rd_val = cap_val[i][BW-1:0];
      end
      for (int j = 0; j < NCMP; j++) begin
         if (bus_addr == AW'(CMP_BASE + 2 * j))     rd_val = cmp_val[j][CW-1:BW];
         if (bus_addr == AW'(CMP_BASE + 2 * j + 1)) rd_val = cmp_val[j][BW-1:0];
      end
      if (bus_addr == AW'(A_CTRL)) rd_val = ctrl_q;
      if (bus_addr == AW'(A_FLAG)) rd_val = BW'(flags);
   end

   assign bus_rdata = bus_rd ? rd_val : '0;
endmodule

// File: rtl/tmr_cc_chk.sv
module tmr_cc_chk #(
   parameter int CW   = 16,
   parameter int NCAP = 2,
   parameter int NCMP = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   tick,
   input logic [CW-1:0]          count,
   input logic [NCAP+NCMP:0]     flags,
   input logic [NCAP+NCMP:0]     flag_clr,
   input logic [NCAP-1:0]        cap_hold,
   input logic [CW-1:0]          cap_val [NCAP],
   input logic [NCMP-1:0]        cmp_hold,
   input logic [NCMP-1:0]        cmp_pin
);
   localparam int OVF_BIT = NCAP + NCMP;

   // R1: counter advances by one on each tick
   p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> count == CW'($past(count) + 1'b1));

   // R1: counter holds between ticks
   p_count_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   // R3: wrap raises the overflow flag
   p_ovf_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && count == '1) |=> flags[OVF_BIT]);

   generate
      for (genvar i = 0; i < NCAP; i++) begin : g_cap_chk
         // R6: frozen latch does not change
         p_cap_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
            cap_hold[i] |=> $stable(cap_val[i]));
      end
      for (genvar j = 0; j < NCMP; j++) begin : g_cmp_chk
         // R8: suspended compare leaves its pin alone
         p_cmp_inhibit_r8: assert property (@(posedge clk) disable iff (!rst_n)
            cmp_hold[j] |=> $stable(cmp_pin[j]));
      end
      for (genvar k = 0; k <= OVF_BIT; k++) begin : g_flag_chk
         // R9: a set flag stays set unless a 1 is written to it
         p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[k] && !flag_clr[k]) |=> flags[k]);
      end
   endgenerate
endmodule

bind tmr_cc_top tmr_cc_chk #(.CW(CW), .NCAP(NCAP), .NCMP(NCMP)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (tick),
   .count    (count),
   .flags    (flags),
   .flag_clr (flag_clr),
   .cap_hold (cap_hold),
   .cap_val  (cap_val),
   .cmp_hold (cmp_hold),
   .cmp_pin  (cmp_pin)
);

// File: tb/tmr_cc_top_tb_top.sv
`timescale 1ns/1ps
module tmr_cc_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [1:0] cap_pin = '0;
   logic [1:0] cmp_pin;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tmr_cc_top dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .cap_pin(cap_pin), .cmp_pin(cmp_pin)
   );

   // behavioural reference model
   int m_cnt, m_snap, m_ctrl, m_flags;
   bit m_held;
   int m_cap [2];
   bit m_caph [2];
   int m_cmp [2];
   bit m_cmph [2];
   bit m_pin [2];
   bit s1 [2], s2 [2], pv [2];
   int setm, clrm, es, act;
   bit rise, fall, trig;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_snap = 0; m_ctrl = 0; m_flags = 0; m_held = 0;
         for (int i = 0; i < 2; i++) begin
            m_cap[i] = 0; m_caph[i] = 0; m_cmp[i] = 16'hFFFF; m_cmph[i] = 0;
            m_pin[i] = 0; s1[i] = 0; s2[i] = 0; pv[i] = 0;
         end
      end else begin
         setm = 0; clrm = 0;
         for (int i = 0; i < 2; i++) begin
            rise = s2[i] && !pv[i];
            fall = !s2[i] && pv[i];
            es = (m_ctrl >> (2 * i)) & 3;
            trig = (es == 1 && rise) || (es == 2 && fall) || (es == 3 && (rise || fall));
            if (trig && !m_caph[i]) begin
               m_cap[i] = m_cnt;
               setm |= (1 << i);
            end
            pv[i] = s2[i]; s2[i] = s1[i]; s1[i] = cap_pin[i];
            if (bus_rd && bus_addr == 4'(2 + 2 * i)) m_caph[i] = 1;
            else if (bus_rd && bus_addr == 4'(3 + 2 * i)) m_caph[i] = 0;
         end
         for (int j = 0; j < 2; j++) begin
            act = (m_ctrl >> (4 + 2 * j)) & 3;
            if (!m_cmph[j] && m_cnt == m_cmp[j]) begin
               if (act == 1) m_pin[j] = !m_pin[j];
               else if (act == 2) m_pin[j] = 0;
               else if (act == 3) m_pin[j] = 1;
               setm |= (1 << (2 + j));
            end
            if (bus_wr && bus_addr == 4'(6 + 2 * j)) begin
               m_cmp[j] = (m_cmp[j] & 'hFF) | (int'(bus_wdata) << 8); m_cmph[j] = 1;
            end
            if (bus_wr && bus_addr == 4'(7 + 2 * j)) begin
               m_cmp[j] = (m_cmp[j] & 'hFF00) | int'(bus_wdata); m_cmph[j] = 0;
            end
         end
         if (m_cnt == 16'hFFFF) setm |= 16;
         if (bus_wr && bus_addr == 4'd11) clrm = int'(bus_wdata) & 31;
         m_flags = ((m_flags & ~clrm) | setm) & 31;
         if (bus_rd && bus_addr == 4'd0) begin m_snap = m_cnt & 'hFF; m_held = 1; end
         else if (bus_rd && bus_addr == 4'd1) m_held = 0;
         if (bus_wr && bus_addr == 4'd10) m_ctrl = int'(bus_wdata);
         m_cnt = (m_cnt + 1) & 'hFFFF;
      end
   end

   function automatic int model_read(input int a);
      case (a)
         0: return m_cnt >> 8;
         1: return m_held ? m_snap : (m_cnt & 'hFF);
         2: return m_cap[0] >> 8;
         3: return m_cap[0] & 'hFF;
         4: return m_cap[1] >> 8;
         5: return m_cap[1] & 'hFF;
         6: return m_cmp[0] >> 8;
         7: return m_cmp[0] & 'hFF;
         8: return m_cmp[1] >> 8;
         9: return m_cmp[1] & 'hFF;
         10: return m_ctrl;
         11: return m_flags;
         default: return 0;
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input int actv, input int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actv, expv);
      end
   endtask

   task automatic step(input bit rd, input bit wr, input int a, input int d, input string tag);
      int expv;
      @(negedge clk);
      bus_rd = rd; bus_wr = wr; bus_addr = 4'(a); bus_wdata = 8'(d);
      #1;
      expv = {30'd0, m_pin[1], m_pin[0]};
      chk(int'(cmp_pin) == expv, "R7 cmp_pin", int'(cmp_pin), expv);
      if (rd) begin
         expv = model_read(a);
         chk(int'(bus_rdata) == expv, tag, int'(bus_rdata), expv);
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, "");
   endtask

   task automatic rd(input int a, input string tag);
      step(1, 0, a, 0, tag);
   endtask

   task automatic wr(input int a, input int d);
      step(0, 1, a, d, "");
   endtask

   task automatic set_cmp(input int ch, input int target);
      wr(6 + 2 * ch, (target >> 8) & 'hFF);
      wr(7 + 2 * ch, target & 'hFF);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R10 reset state
      rd(10, "R10 ctrl reset");
      rd(11, "R10 flags reset");
      rd(6, "R10 cmp0 hi reset");
      rd(9, "R10 cmp1 lo reset");
      chk(cmp_pin == 2'b00, "R10 pins reset", int'(cmp_pin), 0);
      // R1 / R2 counter and snapshot
      rd(1, "R1 live low byte");
      rd(0, "R2 count hi");
      idle(5);
      rd(1, "R2 snapshot low");
      rd(1, "R2 live low after snapshot");
      // R11 readback
      wr(10, 'hDD);
      rd(10, "R11 ctrl readback");
      rd(13, "R11 unmapped");
      // R4 / R5 capture ch0 rising, ch1 both
      cap_pin = 2'b01; idle(6);
      rd(2, "R4 cap0 hi"); rd(3, "R4 cap0 lo");
      rd(11, "R5 cap0 flag");
      cap_pin = 2'b10; idle(6);
      rd(4, "R4 cap1 hi"); rd(5, "R4 cap1 lo");
      rd(11, "R5 both flags");
      cap_pin = 2'b00; idle(6);
      rd(3, "R4 cap0 no capture on fall");
      rd(5, "R4 cap1 capture on fall");
      // R9 flag clear semantics
      wr(11, 0); rd(11, "R9 write zero keeps");
      wr(11, 3); rd(11, "R9 w1c clears");
      // R6 freeze
      rd(2, "R6 freeze hi");
      cap_pin = 2'b01; idle(8);
      rd(11, "R6 no flag while frozen");
      rd(3, "R6 frozen lo");
      cap_pin = 2'b00; idle(4);
      cap_pin = 2'b01; idle(6);
      rd(2, "R6 capture resumes hi"); rd(3, "R6 capture resumes lo");
      // R4 falling select on ch0, off on ch1
      wr(10, 'hD2);
      cap_pin = 2'b10; idle(6);
      rd(3, "R4 falling cap0"); rd(5, "R4 ch1 off");
      // R7 compare actions
      wr(11, 31);
      set_cmp(0, (m_cnt + 30) & 'hFFFF);
      set_cmp(1, (m_cnt + 40) & 'hFFFF);
      idle(50);
      rd(11, "R7 compare flags");
      wr(10, 'h62);  // ch0 clear, ch1 toggle
      set_cmp(0, (m_cnt + 20) & 'hFFFF);
      set_cmp(1, (m_cnt + 25) & 'hFFFF);
      idle(35);
      wr(10, 'h02);  // both none: flag only
      wr(11, 31);
      set_cmp(0, (m_cnt + 10) & 'hFFFF);
      idle(20);
      rd(11, "R7 action none flag");
      // R8 suspended compare
      wr(10, 'hF2);
      wr(11, 31);
      wr(8, ((m_cnt + 12) >> 8) & 'hFF);
      wr(6, ((m_cnt + 12) >> 8) & 'hFF);
      idle(300);
      rd(11, "R8 no match while suspended");
      wr(9, (m_cnt + 5) & 'hFF);
      wr(7, (m_cnt + 5) & 'hFF);
      idle(10);
      rd(11, "R8 matching resumes");
      rd(8, "R11 cmp1 hi readback"); rd(9, "R11 cmp1 lo readback");
      // R3 overflow with clear on the wrap edge
      wr(11, 31);
      while (m_cnt != 16'hFFFF) idle(1);
      wr(11, 16);
      rd(11, "R3 R9 set wins at wrap");
      rd(0, "R1 wrapped hi");
      wr(11, 16);
      rd(11, "R9 overflow cleared");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule